// File: doc/BRIEF.md
# Register Index Redirection Unit

This block translates a 5-bit architectural register number into a 6-bit physical register number, so that an instruction can reach a register file twice the usual size. It holds two programmable lookup tables of 32 entries each. One serves integer operands and the other serves floating-point operands. Each entry carries four fields: an enable bit, a vector bit, an element-width code and a 6-bit destination index.

A disabled entry leaves the register number as it is. An enabled scalar entry replaces the register number with the stored index. An enabled vector entry also adds the caller's running loop offset to the stored index, and returns that offset advanced by one for the next element. The response is registered and is qualified by a valid bit one cycle after the request. A separate write port loads the table entries one at a time.

Top module: `regmap_unit`

## Requirements
- R1: Reset clears every entry of both tables to disabled and drives `rsp_valid` low, so a lookup right after reset returns the requested register number unchanged.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: A disabled entry returns the request register zero-extended to 6 bits, returns the offset unchanged, and reports `rsp_vec`, `rsp_ovf` and `rsp_exc` as 0 when its width code is 0.
- R4: An enabled entry whose vector bit is clear returns the stored index and returns the offset unchanged.
- R5: An enabled entry whose vector bit is set returns (stored index + offset) mod 64 and returns (offset + 1) mod 64, with `rsp_vec` set.
- R6: `rsp_ovf` is 1 exactly when a vector lookup's index plus offset exceeds 63. A sum of exactly 63 does not raise it.
- R7: `rsp_exc` is 1 whenever the addressed entry's element-width code is nonzero, because only the default width (code 0) is supported.
- R8: `req_file`/`wr_file` = 0 selects the integer table and 1 selects the floating-point table. The two tables are independent.
- R9: The write data is packed as bit 9 = enable, bit 8 = vector, bits 7:6 = width code, bits 5:0 = destination index. A write changes lookups only from the following cycle. A lookup in the same cycle sees the old entry.
- R10: An entry with its vector bit set but its enable bit clear behaves as disabled: the register is not redirected and no offset step occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_file | input | 1 | Table chosen for the write (0 integer, 1 floating point) |
| wr_idx | input | 5 | Entry number to write |
| wr_data | input | 10 | Packed entry fields |
| req_valid | input | 1 | Lookup request strobe |
| req_file | input | 1 | Table chosen for the lookup |
| req_reg | input | 5 | Architectural register number |
| req_offs | input | 6 | Incoming loop offset |
| rsp_valid | output | 1 | Response qualifier, one cycle after the request |
| rsp_reg | output | 6 | Physical register number |
| rsp_offs | output | 6 | Offset to use for the next element |
| rsp_vec | output | 1 | Entry was enabled and marked vector |
| rsp_ovf | output | 1 | Vector index sum went past 63 |
| rsp_exc | output | 1 | Unsupported element-width code |

## Verification
The hardest case to reach from the ports is a write and a lookup of the same entry in the same cycle. The bench raises both strobes on one edge and expects the old mapping. It then repeats the lookup one cycle later and expects the new one. The overflow boundary is set up by programming a vector entry at index 60. Offsets of 3, 4 and 63 are then applied, covering the exact-fit case, the first wrap and a wrap of both index and offset. A final mid-run reset after programming shows that the tables really are cleared.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

   typedef enum logic {
      FILE_INT = 1'b0,
      FILE_FP  = 1'b1
   } file_sel_e;

   localparam int NUM_FILES = 2;

endpackage

// File: rtl/regmap_table.sv
module regmap_table #(
   parameter int ARCH_W = 5,
   parameter int ENT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ARCH_W-1:0] waddr,
   input  logic [ENT_W-1:0]  wdata,
   input  logic [ARCH_W-1:0] raddr,
   output logic [ENT_W-1:0]  rdata
);
   localparam int DEPTH = 1 << ARCH_W;

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/regmap_xlate.sv
module regmap_xlate #(
   parameter int ARCH_W = 5,
   parameter int PHYS_W = 6,
   parameter int OFFS_W = 6,
   parameter int EW_W   = 2
) (
   input  logic              ent_on,
   input  logic              ent_vec,
   input  logic [EW_W-1:0]   ent_ew,
   input  logic [PHYS_W-1:0] ent_idx,
   input  logic [ARCH_W-1:0] in_reg,
   input  logic [OFFS_W-1:0] in_offs,
   output logic [PHYS_W-1:0] out_reg,
   output logic [OFFS_W-1:0] out_offs,
   output logic              out_vec,
   output logic              out_ovf,
   output logic              out_exc
);
   localparam int MAX_W = (PHYS_W > OFFS_W) ? PHYS_W : OFFS_W;
   localparam int SUM_W = MAX_W + 1;

   logic [SUM_W-1:0] sum;
   logic             is_vec;

   assign is_vec = ent_on & ent_vec;
   assign sum    = SUM_W'(ent_idx) + SUM_W'(in_offs);

   always_comb begin
      out_reg  = {{(PHYS_W-ARCH_W){1'b0}}, in_reg};
      out_offs = in_offs;
      out_ovf  = 1'b0;
      if (ent_on) begin
         if (is_vec) begin
            out_reg  = sum[PHYS_W-1:0];
            out_offs = in_offs + OFFS_W'(1);
            out_ovf  = |sum[SUM_W-1:PHYS_W];
         end else begin
            out_reg  = ent_idx;
         end
      end
   end

   assign out_vec = is_vec;
   assign out_exc = |ent_ew;

endmodule

// File: rtl/regmap_unit.sv
module regmap_unit
   import regmap_pkg::*;
#(
   parameter int ARCH_W = 5,
   parameter int PHYS_W = 6,
   parameter int OFFS_W = 6,
   parameter int EW_W   = 2,
   localparam int ENT_W = 2 + EW_W + PHYS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_file,
   input  logic [ARCH_W-1:0] wr_idx,
   input  logic [ENT_W-1:0]  wr_data,
   input  logic              req_valid,
   input  logic              req_file,
   input  logic [ARCH_W-1:0] req_reg,
   input  logic [OFFS_W-1:0] req_offs,
   output logic              rsp_valid,
   output logic [PHYS_W-1:0] rsp_reg,
   output logic [OFFS_W-1:0] rsp_offs,
   output logic              rsp_vec,
   output logic              rsp_ovf,
   output logic              rsp_exc
);
   localparam int B_ON  = ENT_W - 1;
   localparam int B_VEC = ENT_W - 2;

   generate
      if (PHYS_W <= ARCH_W) begin : g_bad_phys
         $error("PHYS_W must exceed ARCH_W");
      end
      if (ARCH_W < 1 || OFFS_W < 1 || EW_W < 1) begin : g_bad_w
         $error("widths must be positive");
      end
   endgenerate

   logic [ENT_W-1:0] rd [NUM_FILES];

   generate
      for (genvar f = 0; f < NUM_FILES; f++) begin : g_tbl
         regmap_table #(.ARCH_W(ARCH_W), .ENT_W(ENT_W)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_file == f[0])),
            .waddr (wr_idx),
            .wdata (wr_data),
            .raddr (req_reg),
            .rdata (rd[f])
         );
      end
   endgenerate

   logic [ENT_W-1:0]  ent;
   logic [PHYS_W-1:0] x_reg;
   logic [OFFS_W-1:0] x_offs;
   logic              x_vec, x_ovf, x_exc;

   assign ent = (req_file == FILE_FP) ? rd[1] : rd[0];

   regmap_xlate #(
      .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .OFFS_W(OFFS_W), .EW_W(EW_W)
   ) u_xlate (
      .ent_on   (ent[B_ON]),
      .ent_vec  (ent[B_VEC]),
      .ent_ew   (ent[PHYS_W +: EW_W]),
      .ent_idx  (ent[PHYS_W-1:0]),
      .in_reg   (req_reg),
      .in_offs  (req_offs),
      .out_reg  (x_reg),
      .out_offs (x_offs),
      .out_vec  (x_vec),
      .out_ovf  (x_ovf),
      .out_exc  (x_exc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_reg   <= '0;
         rsp_offs  <= '0;
         rsp_vec   <= 1'b0;
         rsp_ovf   <= 1'b0;
         rsp_exc   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_reg  <= x_reg;
            rsp_offs <= x_offs;
            rsp_vec  <= x_vec;
            rsp_ovf  <= x_ovf;
            rsp_exc  <= x_exc;
         end
      end
   end

endmodule

// File: rtl/regmap_chk.sv
module regmap_chk #(
   parameter int OFFS_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [OFFS_W-1:0] req_offs,
   input logic              rsp_valid,
   input logic [OFFS_W-1:0] rsp_offs,
   input logic              rsp_vec,
   input logic              rsp_ovf
);
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R4 / R3: non-vector responses keep the offset
   a_r4_offs_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid ##1 (rsp_valid && !rsp_vec) |-> rsp_offs == $past(req_offs));

   a_r5_offs_step: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid ##1 (rsp_valid && rsp_vec) |->
         rsp_offs == OFFS_W'($past(req_offs) + OFFS_W'(1)));

   a_r6_ovf_only_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ovf) |-> rsp_vec);

endmodule

bind regmap_unit regmap_chk #(.OFFS_W(OFFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_offs  (req_offs),
   .rsp_valid (rsp_valid),
   .rsp_offs  (rsp_offs),
   .rsp_vec   (rsp_vec),
   .rsp_ovf   (rsp_ovf)
);

// File: tb/tb_regmap_unit.sv
module tb_regmap_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_file = 1'b0;
   logic [4:0] wr_idx = '0;
   logic [9:0] wr_data = '0;
   logic       req_valid = 1'b0, req_file = 1'b0;
   logic [4:0] req_reg = '0;
   logic [5:0] req_offs = '0;
   logic       rsp_valid, rsp_vec, rsp_ovf, rsp_exc;
   logic [5:0] rsp_reg, rsp_offs;

   int nchk = 0, nbad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regmap_unit dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_file(wr_file), .wr_idx(wr_idx), .wr_data(wr_data),
      .req_valid(req_valid), .req_file(req_file), .req_reg(req_reg),
      .req_offs(req_offs),
      .rsp_valid(rsp_valid), .rsp_reg(rsp_reg), .rsp_offs(rsp_offs),
      .rsp_vec(rsp_vec), .rsp_ovf(rsp_ovf), .rsp_exc(rsp_exc)
   );

   // {file, reg[5], offs[6], exp_reg[6], exp_offs[6], vec, ovf, exc}
   localparam logic [26:0] VECS [NV] = '{
      {1'b0, 5'd3,  6'd7,  6'd40, 6'd7,  1'b0, 1'b0, 1'b0}, // R4
      {1'b0, 5'd5,  6'd0,  6'd35, 6'd1,  1'b1, 1'b0, 1'b0}, // R5
      {1'b0, 5'd5,  6'd4,  6'd39, 6'd5,  1'b1, 1'b0, 1'b0}, // R5
      {1'b0, 5'd7,  6'd3,  6'd63, 6'd4,  1'b1, 1'b0, 1'b0}, // R6 exact fit
      {1'b0, 5'd7,  6'd4,  6'd0,  6'd5,  1'b1, 1'b1, 1'b0}, // R6 wrap
      {1'b0, 5'd7,  6'd63, 6'd59, 6'd0,  1'b1, 1'b1, 1'b0}, // R6 double wrap
      {1'b0, 5'd9,  6'd2,  6'd9,  6'd2,  1'b0, 1'b0, 1'b0}, // R10
      {1'b0, 5'd11, 6'd1,  6'd12, 6'd1,  1'b0, 1'b0, 1'b1}, // R7
      {1'b1, 5'd5,  6'd9,  6'd50, 6'd9,  1'b0, 1'b0, 1'b0}, // R8
      {1'b1, 5'd3,  6'd5,  6'd3,  6'd5,  1'b0, 1'b0, 1'b0}, // R8 / R3
      {1'b0, 5'd0,  6'd0,  6'd0,  6'd0,  1'b0, 1'b0, 1'b0}, // R3
      {1'b1, 5'd7,  6'd1,  6'd7,  6'd1,  1'b0, 1'b0, 1'b0}  // R8
   };

   task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic f, input logic [4:0] i, input logic [9:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_file = f; wr_idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // issue a lookup, return the packed response one cycle later
   task automatic look(input logic f, input logic [4:0] r, input logic [5:0] o,
                       output logic [19:0] res);
      req_valid = 1'b1; req_file = f; req_reg = r; req_offs = o;
      @(negedge clk);
      req_valid = 1'b0;
      res = {5'd0, rsp_valid, rsp_reg, rsp_offs, rsp_vec, rsp_ovf, rsp_exc};
   endtask

   initial begin
      logic [19:0] res;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rsp_valid at reset", {19'd0, rsp_valid}, 20'd0);
      rst_n = 1'b1;
      @(negedge clk);
      look(1'b0, 5'd5, 6'd3, res);
      check("R1 cleared table", res, {5'd0, 1'b1, 6'd5, 6'd3, 3'b000});
      // R2: idle request gives no response
      @(negedge clk);
      check("R2 idle", {19'd0, rsp_valid}, 20'd0);

      // R9 packing: [9]=on [8]=vec [7:6]=ew [5:0]=idx
      wr(1'b0, 5'd3,  {1'b1, 1'b0, 2'b00, 6'd40});
      wr(1'b0, 5'd5,  {1'b1, 1'b1, 2'b00, 6'd35});
      wr(1'b0, 5'd7,  {1'b1, 1'b1, 2'b00, 6'd60});
      wr(1'b0, 5'd9,  {1'b0, 1'b1, 2'b00, 6'd50});
      wr(1'b0, 5'd11, {1'b1, 1'b0, 2'b10, 6'd12});
      wr(1'b1, 5'd5,  {1'b1, 1'b0, 2'b00, 6'd50});

      for (int k = 0; k < NV; k++) begin
         logic [26:0] v;
         v = VECS[k];
         @(negedge clk);
         look(v[26], v[25:21], v[20:15], res);
         check($sformatf("vector %0d (R3-R10 table)", k), res,
               {5'd0, 1'b1, v[14:0]});
      end

      // R9: write and lookup of the same entry in one cycle
      @(negedge clk);
      wr_en = 1'b1; wr_file = 1'b0; wr_idx = 5'd20;
      wr_data = {1'b1, 1'b1, 2'b00, 6'd2};
      req_valid = 1'b1; req_file = 1'b0; req_reg = 5'd20; req_offs = 6'd5;
      @(negedge clk);
      wr_en = 1'b0;
      res = {5'd0, rsp_valid, rsp_reg, rsp_offs, rsp_vec, rsp_ovf, rsp_exc};
      check("R9 same-cycle old entry", res, {5'd0, 1'b1, 6'd20, 6'd5, 3'b000});
      look(1'b0, 5'd20, 6'd5, res);
      check("R9 next-cycle new entry", res, {5'd0, 1'b1, 6'd7, 6'd6, 3'b100});
      // R8: fp entry 20 untouched by the integer write
      @(negedge clk);
      look(1'b1, 5'd20, 6'd5, res);
      check("R8 fp unaffected", res, {5'd0, 1'b1, 6'd20, 6'd5, 3'b000});

      // R1: reset after programming clears entries
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      look(1'b0, 5'd7, 6'd2, res);
      check("R1 entries cleared by reset", res, {5'd0, 1'b1, 6'd7, 6'd2, 3'b000});
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

endmodule